// File: doc/BRIEF.md
# Dual-Row Insertion Sorting Queue

This block keeps a short list of keyed entries in ascending order as they arrive, one at a time and at irregular intervals, and hands them back smallest first. Each entry is a single word: a sort key in the upper bits with a position payload in the lower bits, so equal keys are ordered by position. The list is held in two rows of registers. The main row holds the sorted entries, with the smallest at the head. The pass row carries entries that have not yet found their slot.

An arriving entry smaller than the current head goes straight into the head slot, and the main row shifts outward by one. Any other entry drops into the first pass stage. It then moves one stage per clock, comparing itself against the main slot one position further on, until it finds a larger neighbour and inserts there. If several pass stages are ready to insert in the same cycle, the one farthest along wins, and the stages behind it wait. The head is offered for removal only when no entry is still travelling, so the offered head is always the true minimum. The all-ones word marks an empty slot, and enqueuing it changes nothing. A sticky flag reports that an entry was lost because the register rows were full.

Top module: `dual_row_sorter`

## Requirements
- R1: After reset `head_valid` and `lost_flag` are 0 and `head_data` is all ones (every slot empty).
- R2: Entries are ordered by the whole word: key in the upper KEY_W bits, position in the lower POS_W bits. Removal yields them in ascending order. `head_valid` is 1 only when the head slot holds an entry and no entry is travelling in the pass row.
- R3: An enqueued word smaller than the head slot appears on `head_data` on the clock after the one that captured it.
- R4: An enqueued word not smaller than the head enters the pass row and advances one stage per clock. If it settles at main slot p (p ≥ 1), it is inserted on the p-th clock after capture, and `head_valid` is low until then.
- R5: On a cycle where the input goes to the head slot, the pass row holds its contents unchanged.
- R6: When several pass stages are ready to insert on the same clock, only the stage farthest along inserts. The nearer stages keep their entries and insert on a later clock.
- R7: `deq_req` with `head_valid` high and `enq_valid` low removes the head. The next entry appears on the following clock and the tail slot is refilled with all ones. A `deq_req` is ignored on a cycle where `enq_valid` is high or `head_valid` is low.
- R8: Enqueuing the all-ones word has no effect on the stored entries.
- R9: `lost_flag` is set, and stays set until reset, whenever an entry is lost. An entry is lost when an insertion pushes an occupied tail out, when a pass entry leaves the last pass stage, or when a load finds the first pass stage held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_data | input | KEY_W+POS_W | Entry to insert: key above, position below |
| deq_req | input | 1 | Request to remove the head entry |
| head_valid | output | 1 | Head holds an entry and nothing is travelling |
| head_data | output | KEY_W+POS_W | Current head slot (smallest entry) |
| lost_flag | output | 1 | Sticky: an entry was lost for lack of room |

## Verification
The checks assume that the caller never stores more entries than DEPTH. They also assume that a new word is never offered while the first pass stage is held behind another insertion. Under these assumptions no entry is lost, and the main row stays sorted at every clock. The stimulus keeps within them. It waits long enough between loads for the rows to settle, except in the back-to-back sequence, whose stage occupancy is traced by hand. Only the deliberate full-queue case crosses the capacity limit, and there the flag is expected to rise.

// File: rtl/dual_row_sorter_pkg.sv
package dual_row_sorter_pkg;

    // Action taken by the sorter on a given clock
    typedef enum logic [1:0] {
        ACT_STEP = 2'd0,  // pass row advances / inserts
        ACT_HEAD = 2'd1,  // input goes to main head, pass row frozen
        ACT_LOAD = 2'd2,  // pass row advances and input enters first pass stage
        ACT_POP  = 2'd3   // head removed, main row shifts toward head
    } act_e;

endpackage

// File: rtl/sorter_ready.sv
module sorter_ready #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int PST  = DEPTH - 1
) (
    input  logic [PST-1:0][W-1:0] next_main_i, // main slots 1..DEPTH-1
    input  logic [PST-1:0][W-1:0] pass_i,
    output logic [PST-1:0]        occ_o,
    output logic [PST-1:0]        ready_o
);
    localparam logic [W-1:0] EMPTY = '1;

    // One comparator per pass stage against the following main slot
    for (genvar g = 0; g < PST; g++) begin : g_stage
        assign occ_o[g]   = (pass_i[g] != EMPTY);
        assign ready_o[g] = occ_o[g] && (pass_i[g] < next_main_i[g]);
    end
endmodule

// File: rtl/sorter_pick.sv
module sorter_pick #(
    parameter int N     = 7,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    // Farthest-along requester wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dual_row_sorter.sv
module dual_row_sorter
    import dual_row_sorter_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int POS_W = 4,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_valid,
    input  logic [KEY_W+POS_W-1:0]   enq_data,
    input  logic                     deq_req,
    output logic                     head_valid,
    output logic [KEY_W+POS_W-1:0]   head_data,
    output logic                     lost_flag
);
    localparam int W      = KEY_W + POS_W;
    localparam int PST    = DEPTH - 1;
    localparam int PIDX_W = (PST > 1) ? $clog2(PST) : 1;
    localparam logic [W-1:0] EMPTY = '1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] main;
        logic [PST-1:0][W-1:0]   pass;
        logic                    lost;
    } st_t;

    st_t               st_d, st_q;
    logic [PST-1:0]    occ;
    logic [PST-1:0]    rdy;
    logic              win_v;
    logic [PIDX_W-1:0] win_idx;
    logic              pass_empty;
    act_e              act;

    sorter_ready #(.W(W), .DEPTH(DEPTH)) u_ready (
        .next_main_i (st_q.main[DEPTH-1:1]),
        .pass_i      (st_q.pass),
        .occ_o       (occ),
        .ready_o     (rdy)
    );

    sorter_pick #(.N(PST), .IDX_W(PIDX_W)) u_pick (
        .req_i (rdy),
        .hit_o (win_v),
        .idx_o (win_idx)
    );

    assign pass_empty = ~|occ;
    assign head_data  = st_q.main[0];
    assign head_valid = (st_q.main[0] != EMPTY) && pass_empty;
    assign lost_flag  = st_q.lost;

    // Action select: a real enqueue always has the cycle
    always_comb begin
        if (enq_valid && (enq_data != EMPTY)) begin
            act = (enq_data < st_q.main[0]) ? ACT_HEAD : ACT_LOAD;
        end else if (deq_req && head_valid && !enq_valid) begin
            act = ACT_POP;
        end else begin
            act = ACT_STEP;
        end
    end

    // Next-state computation
    always_comb begin
        int k;
        st_d = st_q;
        k    = int'(win_idx);
        case (act)
            ACT_HEAD: begin
                st_d.main[0] = enq_data;
                for (int j = 1; j < DEPTH; j++) st_d.main[j] = st_q.main[j-1];
                if (st_q.main[DEPTH-1] != EMPTY) st_d.lost = 1'b1;
            end
            ACT_POP: begin
                for (int j = 0; j < DEPTH-1; j++) st_d.main[j] = st_q.main[j+1];
                st_d.main[DEPTH-1] = EMPTY;
            end
            default: begin
                // insertion of the winning pass stage at main slot k+1
                if (win_v) begin
                    for (int j = 1; j < DEPTH; j++) begin
                        if (j == k + 1)     st_d.main[j] = st_q.pass[k];
                        else if (j > k + 1) st_d.main[j] = st_q.main[j-1];
                    end
                    if (st_q.main[DEPTH-1] != EMPTY) st_d.lost = 1'b1;
                end
                // stages behind the winner hold, the rest vacate
                for (int i = 0; i < PST; i++) begin
                    if (win_v && (i < k)) st_d.pass[i] = st_q.pass[i];
                    else                  st_d.pass[i] = EMPTY;
                end
                // stages beyond the winner (or all, with no winner) advance
                for (int i = 1; i < PST; i++) begin
                    if (!win_v || ((i - 1) > k)) st_d.pass[i] = st_q.pass[i-1];
                end
                if ((!win_v || ((PST - 1) > k)) && (st_q.pass[PST-1] != EMPTY))
                    st_d.lost = 1'b1;
                if (act == ACT_LOAD) begin
                    if (st_d.pass[0] == EMPTY) st_d.pass[0] = enq_data;
                    else                       st_d.lost    = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.main <= '1;
            st_q.pass <= '1;
            st_q.lost <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dual_row_sorter_chk.sv
module dual_row_sorter_chk #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int PST  = DEPTH - 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enq_valid,
    input logic [W-1:0]            enq_data,
    input logic                    deq_req,
    input logic                    head_valid,
    input logic [W-1:0]            head_data,
    input logic                    lost_flag,
    input logic [DEPTH-1:0][W-1:0] main_i,
    input logic [PST-1:0][W-1:0]   pass_i
);
    localparam logic [W-1:0] EMPTY = '1;

    function automatic logic ascending(input logic [DEPTH-1:0][W-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DEPTH-1; i++) if (m[i] > m[i+1]) ok = 1'b0;
        return ok;
    endfunction

    // R2: the main row is in ascending order on every clock
    a_r2_main_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        ascending(main_i));

    // R3: a word below the head becomes the head one clock later
    a_r3_head_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && (enq_data != EMPTY) && (enq_data < main_i[0]))
        |=> (head_data == $past(enq_data)));

    // R5: pass row is untouched while the head takes the input
    a_r5_pass_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && (enq_data != EMPTY) && (enq_data < main_i[0]))
        |=> (pass_i == $past(pass_i)));

    // R7: an accepted removal exposes the second entry
    a_r7_pop_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && head_valid && !enq_valid)
        |=> (head_data == $past(main_i[1])));

    // R9: the loss flag never clears on its own
    a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lost_flag |=> lost_flag);
endmodule

bind dual_row_sorter dual_row_sorter_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_data   (enq_data),
    .deq_req    (deq_req),
    .head_valid (head_valid),
    .head_data  (head_data),
    .lost_flag  (lost_flag),
    .main_i     (st_q.main),
    .pass_i     (st_q.pass)
);

// File: tb/dual_row_sorter_tb.sv
`timescale 1ns/1ps
module dual_row_sorter_tb;
    localparam int KEY_W = 8;
    localparam int POS_W = 4;
    localparam int DEPTH = 8;
    localparam int W     = KEY_W + POS_W;
    localparam logic [W-1:0] EMPTY = '1;

    // {word to enqueue, expected head once settled}
    localparam logic [2*W-1:0] VEC [0:7] = '{
        {12'h5A3, 12'h5A3}, {12'h2F1, 12'h2F1}, {12'h7C0, 12'h2F1},
        {12'h2F0, 12'h2F0}, {12'h901, 12'h2F0}, {12'h150, 12'h150},
        {12'h5A2, 12'h150}, {12'hC33, 12'h150}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enq_valid = 1'b0;
    logic [W-1:0] enq_data = '0;
    logic         deq_req = 1'b0;
    logic         head_valid;
    logic [W-1:0] head_data;
    logic         lost_flag;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [W-1:0] srt [0:7];

    always #2.5 clk = ~clk;

    dual_row_sorter #(.KEY_W(KEY_W), .POS_W(POS_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
        .deq_req(deq_req), .head_valid(head_valid), .head_data(head_data),
        .lost_flag(lost_flag)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enq(input logic [W-1:0] v);
        @(negedge clk);
        enq_valid = 1'b1;
        enq_data  = v;
        @(negedge clk);
        enq_valid = 1'b0;
        enq_data  = '0;
    endtask

    // called on a falling edge
    task automatic pop_expect(input logic [W-1:0] exp, input string tag);
        check(head_valid == 1'b1, {tag, " head_valid"}, W'(head_valid), W'(1));
        check(head_data == exp, tag, head_data, exp);
        deq_req = 1'b1;
        @(negedge clk);
        deq_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        // expected removal order of the table, computed here
        for (int i = 0; i < 8; i++) srt[i] = VEC[i][2*W-1:W];
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 7 - i; j++)
                if (srt[j] > srt[j+1]) begin
                    logic [W-1:0] t;
                    t = srt[j]; srt[j] = srt[j+1]; srt[j+1] = t;
                end

        do_reset();
        check(head_valid == 1'b0, "R1 head_valid", W'(head_valid), W'(0));
        check(lost_flag == 1'b0, "R1 lost_flag", W'(lost_flag), W'(0));
        check(head_data == EMPTY, "R1 head_data", head_data, EMPTY);

        // table walk: settled head after each load (R2, R3, R4)
        for (int i = 0; i < 8; i++) begin
            enq(VEC[i][2*W-1:W]);
            idle(DEPTH + 1);
            check(head_data == VEC[i][W-1:0], "R2 settled head", head_data, VEC[i][W-1:0]);
        end
        check(lost_flag == 1'b0, "R9 no loss at capacity", W'(lost_flag), W'(0));

        // all-ones load with a removal request in the same cycle (R7, R8)
        @(negedge clk);
        enq_valid = 1'b1; enq_data = EMPTY; deq_req = 1'b1;
        @(negedge clk);
        enq_valid = 1'b0; enq_data = '0; deq_req = 1'b0;
        idle(1);
        check(head_data == srt[0], "R7 pop ignored with enq", head_data, srt[0]);
        check(head_valid == 1'b1, "R8 marker no effect", W'(head_valid), W'(1));

        // overflow by a head insertion into a full queue (R3, R9)
        enq(12'h010);
        check(head_data == 12'h010, "R3 head next clock", head_data, 12'h010);
        check(lost_flag == 1'b1, "R9 lost on push-out", W'(lost_flag), W'(1));
        idle(2);
        pop_expect(12'h010, "R9 order after loss");
        for (int i = 0; i < 7; i++) pop_expect(srt[i], "R2 ascending removal");
        check(head_valid == 1'b0, "R7 empty after removal", W'(head_valid), W'(0));
        check(head_data == EMPTY, "R7 tail refilled", head_data, EMPTY);
        check(lost_flag == 1'b1, "R9 sticky", W'(lost_flag), W'(1));

        do_reset();
        check(lost_flag == 1'b0, "R1 reset clears loss", W'(lost_flag), W'(0));

        // travel timing: 0x800 settles at slot 3 (R4)
        enq(12'h100); idle(DEPTH + 1);
        enq(12'h300); idle(DEPTH + 1);
        enq(12'h400); idle(DEPTH + 1);
        enq(12'h800);
        check(head_valid == 1'b0, "R4 travelling after capture", W'(head_valid), W'(0));
        idle(2);
        check(head_valid == 1'b0, "R4 still travelling clk2", W'(head_valid), W'(0));
        idle(1);
        check(head_valid == 1'b1, "R4 settled on clk3", W'(head_valid), W'(1));
        pop_expect(12'h100, "R4 order");
        pop_expect(12'h300, "R4 order");
        pop_expect(12'h400, "R4 order");
        pop_expect(12'h800, "R4 order");

        // back-to-back loads: freeze and two-stage contention (R5, R6)
        @(negedge clk); enq_valid = 1'b1; enq_data = 12'h100;
        @(negedge clk); enq_data = 12'h500;
        @(negedge clk); enq_data = 12'h050;
        @(negedge clk); enq_data = 12'h080;
        @(negedge clk); enq_valid = 1'b0; enq_data = '0;
        check(head_data == 12'h050, "R5 head after frozen cycle", head_data, 12'h050);
        check(head_valid == 1'b0, "R6 two in flight", W'(head_valid), W'(0));
        idle(1);
        check(head_valid == 1'b0, "R6 nearer stage stalled", W'(head_valid), W'(0));
        idle(1);
        check(head_valid == 1'b1, "R6 nearer stage inserted", W'(head_valid), W'(1));
        pop_expect(12'h050, "R5 order");
        pop_expect(12'h080, "R6 order");
        pop_expect(12'h100, "R6 order");
        pop_expect(12'h500, "R5 order");
        check(lost_flag == 1'b0, "R9 no loss in contention", W'(lost_flag), W'(0));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule